// File: doc/BRIEF.md
# BCD Leap Year Detector

This block decides whether a year, given as four packed BCD digits, is a leap year under the Gregorian rule. It never converts the year to binary and never divides. It reads the parity of the tens digit and the two low bits of the ones digit to decide divisibility by 4. A century year is found by testing that both low digits are zero. Divisibility by 400 uses the same pair test on the thousands and hundreds digits. The three partial results are available as outputs so that surrounding logic can use them directly.

Each digit is also checked for codes 10 to 15. Any such code raises an error output and forces the leap result low. A parameter selects between two builds. One is purely combinational. The other captures the result on an input strobe and presents it one clock later with its own valid flag. The rule applies to years after the 1582 calendar reform. Binary-coded years are not accepted.

Top module: `bcd_leap_detect`

## Requirements
- R1: The year is packed as thousands in bits 15:12, hundreds in bits 11:8, tens in bits 7:4 and ones in bits 3:0. For a valid year, `div4` is 1 exactly when the value of the two lowest digits is a multiple of 4.
- R2: For a valid year, `div100` is 1 exactly when the tens and ones digits are both zero.
- R3: For a valid year, `div400` is 1 exactly when `div100` is 1 and the value of the two highest digits is a multiple of 4.
- R4: For a valid year, `leap` equals (`div4` and not `div100`) or `div400`.
- R5: `bcd_error` is 1 when any digit holds a code from 10 to 15. While it is 1, `leap` is 0, even when the low bits would otherwise pass the divisibility tests.
- R6: With REG_STAGE=1, a year presented with `in_valid` high at a rising edge appears on the result outputs after that edge, together with `out_valid` high, for one cycle.
- R7: With REG_STAGE=1, a cycle with `in_valid` low gives `out_valid` low on the next cycle. The result outputs keep the values from the last captured year, whatever the year input holds.
- R8: With REG_STAGE=1, while `rst_n` is low, `out_valid` and every result output are 0.
- R9: With REG_STAGE=0, the result outputs follow `year_bcd` in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe qualifying `year_bcd` |
| year_bcd | input | 16 | Year as four BCD digits, thousands digit most significant |
| out_valid | output | 1 | Result outputs hold a fresh result |
| leap | output | 1 | Gregorian leap-year flag |
| div4 | output | 1 | Year is divisible by 4 |
| div100 | output | 1 | Year is divisible by 100 |
| div400 | output | 1 | Year is divisible by 400 |
| bcd_error | output | 1 | At least one digit is not a BCD code |

## Verification
The hardest case to reach from the ports is a bad digit whose low bits still pass the divisibility tests. An example is tens 2 with ones code 12: the raw rule would report a leap year, so only the error override keeps `leap` low. The stimulus builds such years on purpose. It places every illegal code in every digit position over a base year, 2024 or 2000, that is itself leap. The hold case is reached the same way: a known leap year is captured, then a non-leap year is presented with the strobe low, so that any result that leaks through changes the outputs.

// File: rtl/leap_pkg.sv
package leap_pkg;
   // Largest legal code in one decimal digit
   localparam int BCD_MAX = 9;

   typedef struct packed {
      logic leap;
      logic div4;
      logic div100;
      logic div400;
      logic bcd_error;
   } leap_res_t;
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
   import leap_pkg::*;
#(
   parameter int DIGIT_W = 4
) (
   input  logic [DIGIT_W-1:0] digit,
   output logic               invalid
);
   if (DIGIT_W < 4) begin : g_bad_width
      $error("bcd_digit_check: DIGIT_W must be at least 4");
   end

   assign invalid = (digit > DIGIT_W'(BCD_MAX));
endmodule

// File: rtl/bcd_pair_div4.sv
// Decides whether the two-digit number (tens, ones) is a multiple of 4.
// 100 is itself a multiple of 4, so only 10*t + o matters, and 10*t mod 4
// is 0 for an even t and 2 for an odd t. Only legal BCD codes are assumed.
module bcd_pair_div4 (
   input  logic       tens_lsb,
   input  logic [1:0] ones_low,
   output logic       div4
);
   always_comb begin
      if (tens_lsb)
         div4 = (ones_low == 2'b10);
      else
         div4 = (ones_low == 2'b00);
   end
endmodule

// File: rtl/leap_core.sv
module leap_core
   import leap_pkg::*;
#(
   parameter int DIGITS  = 4,
   parameter int DIGIT_W = 4
) (
   input  logic [DIGITS*DIGIT_W-1:0] year,
   output leap_res_t                 res
);
   localparam int LOW_W = 2 * DIGIT_W;

   // Digit slots: 0 ones, 1 tens, 2 hundreds, 3 thousands
   localparam int ONES = 0;
   localparam int TENS = 1;
   localparam int HUND = 2;
   localparam int THOU = 3;

   logic [DIGITS-1:0] digit_bad;
   logic              low_pair4;
   logic              high_pair4;
   logic              low_zero;
   logic              raw_leap;

   for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
      bcd_digit_check #(.DIGIT_W(DIGIT_W)) u_check (
         .digit   (year[gi*DIGIT_W +: DIGIT_W]),
         .invalid (digit_bad[gi])
      );
   end

   bcd_pair_div4 u_low_pair (
      .tens_lsb (year[TENS*DIGIT_W]),
      .ones_low (year[ONES*DIGIT_W +: 2]),
      .div4     (low_pair4)
   );

   bcd_pair_div4 u_high_pair (
      .tens_lsb (year[THOU*DIGIT_W]),
      .ones_low (year[HUND*DIGIT_W +: 2]),
      .div4     (high_pair4)
   );

   assign low_zero = ~|year[LOW_W-1:0];
   assign raw_leap = (low_pair4 & ~low_zero) | (high_pair4 & low_zero);

   always_comb begin
      res.div4      = low_pair4;
      res.div100    = low_zero;
      res.div400    = high_pair4 & low_zero;
      res.bcd_error = |digit_bad;
      res.leap      = raw_leap & ~(|digit_bad);
   end
endmodule

// File: rtl/bcd_leap_detect.sv
module bcd_leap_detect
   import leap_pkg::*;
#(
   parameter int DIGITS    = 4,
   parameter int DIGIT_W   = 4,
   parameter bit REG_STAGE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [DIGITS*DIGIT_W-1:0] year_bcd,
   output logic                      out_valid,
   output logic                      leap,
   output logic                      div4,
   output logic                      div100,
   output logic                      div400,
   output logic                      bcd_error
);
   if (DIGITS != 4) begin : g_bad_digits
      $error("bcd_leap_detect: the rule needs exactly four digits");
   end
   if (DIGIT_W != 4) begin : g_bad_dw
      $error("bcd_leap_detect: BCD digits are four bits wide");
   end

   leap_res_t core_res;
   leap_res_t out_res;

   leap_core #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_core (
      .year (year_bcd),
      .res  (core_res)
   );

   if (REG_STAGE) begin : g_reg
      leap_res_t res_q;
      logic      valid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= in_valid;
            if (in_valid)
               res_q <= core_res;
         end
      end

      assign out_res   = res_q;
      assign out_valid = valid_q;

      // R6
      capture_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R7
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(leap) && $stable(bcd_error) && $stable(div4)));
   end else begin : g_comb
      assign out_res   = core_res;
      assign out_valid = in_valid;
   end

   assign leap      = out_res.leap;
   assign div4      = out_res.div4;
   assign div100    = out_res.div100;
   assign div400    = out_res.div400;
   assign bcd_error = out_res.bcd_error;

   // R5
   error_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_error |-> !leap);

   // R2
   century_is_div4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div100 |-> div4);

   // R3
   div400_parts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div400 |-> (div100 && div4));

   // R4
   plain_century_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div100 && !div400) |-> !leap);
endmodule

// File: tb/bcd_leap_detect_test.sv
`timescale 1ns/1ps
module bcd_leap_detect_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] year = 16'h0000;

   logic r_ov, r_lp, r_d4, r_d100, r_d400, r_err;
   logic c_ov, c_lp, c_d4, c_d100, c_d400, c_err;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   logic [5:0] pend_exp;
   logic [5:0] pend_mask;
   bit         pend = 1'b0;
   string      pend_tag;

   always #2 clk = ~clk;

   bcd_leap_detect #(.REG_STAGE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .year_bcd(year),
      .out_valid(r_ov), .leap(r_lp), .div4(r_d4), .div100(r_d100),
      .div400(r_d400), .bcd_error(r_err));

   bcd_leap_detect #(.REG_STAGE(1'b0)) uut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .year_bcd(year),
      .out_valid(c_ov), .leap(c_lp), .div4(c_d4), .div100(c_d100),
      .div400(c_d400), .bcd_error(c_err));

   // Packing: {valid, leap, div4, div100, div400, error}
   wire [5:0] reg_vec  = {r_ov, r_lp, r_d4, r_d100, r_d400, r_err};
   wire [5:0] comb_vec = {c_ov, c_lp, c_d4, c_d100, c_d400, c_err};

   function automatic logic [15:0] to_bcd(input int y);
      return {4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
   endfunction

   function automatic logic [5:0] model(input int y);
      logic d4, d100, d400, lp;
      d4   = ((y % 100) % 4) == 0;
      d100 = (y % 100) == 0;
      d400 = (y % 400) == 0;
      lp   = ((y % 4) == 0 && (y % 100) != 0) || d400;
      return {1'b1, lp, d4, d100, d400, 1'b0};
   endfunction

   task automatic cmp(input string req, input logic [5:0] act,
                      input logic [5:0] exp, input logic [5:0] mask);
      vectors++;
      if ((act & mask) !== (exp & mask)) begin
         misses++;
         $display("FAIL %s actual=%b expected=%b", req, act & mask, exp & mask);
      end
   endtask

   // Present one strobed year; checks the previous one on the registered uut
   task automatic apply(input logic [15:0] y, input logic [5:0] exp,
                        input logic [5:0] mask, input string tag);
      @(negedge clk);
      if (pend) cmp({pend_tag, " R6"}, reg_vec, pend_exp, pend_mask);
      year     = y;
      in_valid = 1'b1;
      #1 cmp({tag, " R9"}, comb_vec, exp, mask);
      pend      = 1'b1;
      pend_exp  = exp;
      pend_mask = mask;
      pend_tag  = tag;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state of the registered build
      cmp("R8", reg_vec, 6'b000000, 6'b111111);
      rst_n = 1'b1;

      // R1 R2 R3 R4: every valid year after the reform
      for (int y = 1583; y <= 9999; y++)
         apply(to_bcd(y), model(y), 6'b111111, "R1 R2 R3 R4");

      // R5: each illegal code in each digit, over leap base years
      for (int pos = 0; pos < 4; pos++) begin
         for (int code = 10; code <= 15; code++) begin
            logic [15:0] a, b;
            a = to_bcd(2024);
            b = to_bcd(2000);
            a[pos*4 +: 4] = 4'(code);
            b[pos*4 +: 4] = 4'(code);
            apply(a, 6'b100001, 6'b110001, "R5");
            apply(b, 6'b100001, 6'b110001, "R5");
         end
      end

      // R7: capture 2000, then idle with a non-leap year on the input
      apply(to_bcd(2000), model(2000), 6'b111111, "R3 R4");
      @(negedge clk);
      cmp({pend_tag, " R6"}, reg_vec, pend_exp, pend_mask);
      pend     = 1'b0;
      in_valid = 1'b0;
      year     = to_bcd(1999);
      #1 cmp("R9", comb_vec, {1'b0, model(1999)[4:0]}, 6'b111111);
      @(negedge clk);
      cmp("R7", reg_vec, {1'b0, model(2000)[4:0]}, 6'b111111);
      @(negedge clk);
      cmp("R7", reg_vec, {1'b0, model(2000)[4:0]}, 6'b111111);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++;
         misses++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule